// File: doc/BRIEF.md
# I2C Transmit/Receive FIFO Pair

This block holds the byte queues that sit between a host register port and an I2C bit engine. The transmit side queues 10-bit entries. Each entry is a data byte plus two flags that tell the bit engine to issue a start condition before the byte or a stop condition after it. The receive side queues bytes captured by the bit engine. The bit engine itself is not part of this block. It is modelled by a pop strobe on the transmit side and a push strobe on the receive side.

The host reaches the block through a single-cycle port made of a valid, a write flag, a 3-bit address and write data. Read data is combinational on the addressed register. A write to the transmit data address queues an entry. A read of the receive data address returns the oldest byte and removes it. Occupancy registers report the entry count minus one. The receive threshold register uses the same zero-based convention. Three level-sensitive interrupt conditions are provided:
- transmit queue empty;
- transmit queue at or below half full;
- receive occupancy equal to the threshold plus one.

A control bit holds the transmit queue flushed for as long as it is set.

Top module: `i2c_fifo_pair`

Register addresses (host_addr): 0 control, 1 status, 2 transmit data, 3 receive data, 4 transmit occupancy, 5 receive occupancy, 6 receive threshold, 7 debug.

## Requirements
- R1: After reset the following hold: both queues are empty, status reads 0xC0, the threshold reads 0, the debug register reads 0, irq_tx_empty and irq_tx_half are 1, and irq_rx_full is 0.
- R2: Transmit entries leave on tx_head in the order they were written, with all 10 bits intact. Bit 8 is the start request and bit 9 is the stop request. A tx_pop while the queue is not empty removes the head entry at the next clock edge.
- R3: A write to transmit data (address 2) while the transmit queue holds 16 entries is discarded. It sets bit 0 of the debug register (address 7), which stays set until reset.
- R4: The occupancy registers (address 4 transmit, address 5 receive) read the entry count minus one. They read 0 when the queue is empty.
- R5: Status (address 1) has the following fields: bit 7 transmit empty, bit 6 receive empty, bit 5 receive holds 16 entries, bit 4 transmit holds 16 entries. All other bits read 0.
- R6: irq_rx_full is 1 exactly when the receive count equals the threshold register (address 6, 4 bits) plus one.
- R7: irq_tx_half is 1 while the transmit count is 8 or less. irq_tx_empty is 1 while the count is 0.
- R8: While control bit 1 (address 0, value 0x002) is set, the transmit queue is empty and transmit data writes are discarded without setting the overflow bit. Writing 0 to the control register releases the queue.
- R9: A host read of receive data (address 3) returns the oldest byte and removes it. A read while the queue is empty returns 0 and changes nothing.
- R10: An rx_push while the receive queue holds 16 entries is discarded. A tx_pop while the transmit queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 10 | Write data |
| host_rdata | output | 10 | Read data of the addressed register |
| tx_pop | input | 1 | Bit engine takes the head transmit entry |
| tx_head | output | 10 | Head transmit entry (0 when empty) |
| rx_push | input | 1 | Bit engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| irq_tx_empty | output | 1 | Transmit queue empty |
| irq_tx_half | output | 1 | Transmit queue at or below half |
| irq_rx_full | output | 1 | Receive count reached threshold plus one |

## Verification
The assertions assume that the host issues at most one access per cycle. The counter-step properties assume that no host pop or transmit write coincides with the engine strobe they examine; otherwise they do not constrain the count. The stimulus keeps host accesses and engine strobes in separate cycles. It also always releases a strobe one cycle after raising it, so each property's antecedent sees a single isolated event. Full and empty corner cases are reached by filling each queue to 16 entries and then pushing once more, and by reading or popping a queue that is already empty.

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair #(
  parameter int DEPTH = 16,
  parameter int TXW   = 10,
  parameter int RXW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_valid,
  input  logic           host_write,
  input  logic [2:0]     host_addr,
  input  logic [TXW-1:0] host_wdata,
  output logic [TXW-1:0] host_rdata,
  input  logic           tx_pop,
  output logic [TXW-1:0] tx_head,
  input  logic           rx_push,
  input  logic [RXW-1:0] rx_byte,
  output logic           irq_tx_empty,
  output logic           irq_tx_half,
  output logic           irq_rx_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TXD = 3'd2, A_RXD = 3'd3,
                         A_TXO  = 3'd4, A_RXO  = 3'd5, A_THR = 3'd6, A_DBG = 3'd7;

  logic [TXW-1:0] tx_mem [DEPTH];
  logic [RXW-1:0] rx_mem [DEPTH];
  logic [AW-1:0]  tx_rp, tx_wp, rx_rp, rx_wp, rx_thr;
  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           tx_flush, tx_ovf;

  wire host_wr = host_valid & host_write;
  wire host_rd = host_valid & ~host_write;
  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == FULL_CNT);
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL_CNT);

  wire tx_wr_req  = host_wr && host_addr == A_TXD;
  wire tx_do_push = tx_wr_req & ~tx_full & ~tx_flush;
  wire tx_do_pop  = tx_pop & ~tx_empty & ~tx_flush;
  wire rx_do_push = rx_push & ~rx_full;
  wire rx_do_pop  = host_rd && host_addr == A_RXD && !rx_empty;

  wire [AW-1:0] tx_occ = tx_empty ? '0 : AW'(tx_cnt - 1'b1);
  wire [AW-1:0] rx_occ = rx_empty ? '0 : AW'(rx_cnt - 1'b1);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // Control, threshold and sticky overflow (R1, R3, R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flush <= 1'b0;
      rx_thr   <= '0;
      tx_ovf   <= 1'b0;
    end else begin
      if (host_wr && host_addr == A_CTRL) tx_flush <= host_wdata[1];
      if (host_wr && host_addr == A_THR)  rx_thr   <= host_wdata[AW-1:0];
      if (tx_wr_req && tx_full && !tx_flush) tx_ovf <= 1'b1;
    end
  end

  // Transmit queue (R2, R8, R10)
  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush) begin
      tx_rp  <= '0;
      tx_wp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_do_push) tx_wp <= nxt(tx_wp);
      if (tx_do_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_do_push) - CW'(tx_do_pop);
    end
  end

  always_ff @(posedge clk)
    if (tx_do_push) tx_mem[tx_wp] <= host_wdata;

  // Receive queue (R9, R10)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rp  <= '0;
      rx_wp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_do_push) rx_wp <= nxt(rx_wp);
      if (rx_do_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_do_push) - CW'(rx_do_pop);
    end
  end

  always_ff @(posedge clk)
    if (rx_do_push) rx_mem[rx_wp] <= rx_byte;

  assign tx_head      = tx_empty ? '0 : tx_mem[tx_rp];
  assign irq_tx_empty = tx_empty;
  assign irq_tx_half  = (tx_cnt <= HALF_CNT);
  assign irq_rx_full  = (rx_cnt == {1'b0, rx_thr} + 1'b1);

  // Register read mux (R4, R5)
  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRL:  host_rdata = TXW'({tx_flush, 1'b0});
      A_STAT:  host_rdata = TXW'({tx_empty, rx_empty, rx_full, tx_full, 4'b0000});
      A_RXD:   host_rdata = rx_empty ? '0 : TXW'(rx_mem[rx_rp]);
      A_TXO:   host_rdata = TXW'(tx_occ);
      A_RXO:   host_rdata = TXW'(rx_occ);
      A_THR:   host_rdata = TXW'(rx_thr);
      A_DBG:   host_rdata = TXW'(tx_ovf);
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_fifo_pair_chk.sv
module i2c_fifo_pair_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_valid,
  input logic          host_write,
  input logic [2:0]    host_addr,
  input logic          tx_pop,
  input logic          rx_push,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_flush,
  input logic          tx_ovf,
  input logic          irq_tx_empty,
  input logic          irq_tx_half,
  input logic          irq_rx_full
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  wire host_pop = host_valid && !host_write && host_addr == 3'd3;
  wire host_txw = host_valid && host_write && host_addr == 3'd2;

  p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL_CNT);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n) tx_ovf |=> tx_ovf);
  p_tx_pop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_cnt != '0 && !tx_flush && !host_txw) |=> (tx_cnt + 1'b1 == $past(tx_cnt)));
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n) tx_flush |=> tx_cnt == '0);
  p_empty_in_half_r7: assert property (@(posedge clk) disable iff (!rst_n) irq_tx_empty |-> irq_tx_half);
  p_rxirq_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n) irq_rx_full |-> rx_cnt != '0);
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && host_pop && !rx_push) |=> rx_cnt == '0);
  p_rx_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULL_CNT && rx_push && !host_pop) |=> rx_cnt == FULL_CNT);
endmodule

bind i2c_fifo_pair i2c_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_addr(host_addr), .tx_pop(tx_pop), .rx_push(rx_push), .tx_cnt(tx_cnt),
  .rx_cnt(rx_cnt), .tx_flush(tx_flush), .tx_ovf(tx_ovf), .irq_tx_empty(irq_tx_empty),
  .irq_tx_half(irq_tx_half), .irq_rx_full(irq_rx_full));

// File: tb/i2c_fifo_pair_test.sv
module i2c_fifo_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OP_WR = 0, OP_RD = 1, OP_RXP = 2, OP_TXP = 3, OP_IRQ = 4;

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] req,
                                     input logic [2:0] a, input logic [9:0] d, input logic [9:0] e);
    return {op, req, 1'b0, a, d, e};
  endfunction

  localparam int NV = 35;
  localparam logic [31:0] VEC [NV] = '{
    mk(OP_RD, 5, 1, 0, 10'h0C0),   // R5 status after reset
    mk(OP_RD, 4, 4, 0, 10'h000),   // R4
    mk(OP_IRQ, 1, 0, 0, 10'h003),  // R1
    mk(OP_WR, 2, 2, 10'h1A5, 0),   // R2 start + A5
    mk(OP_WR, 2, 2, 10'h233, 0),   // R2 stop + 33
    mk(OP_RD, 4, 4, 0, 10'h001),   // R4 two entries
    mk(OP_IRQ, 7, 0, 0, 10'h002),  // R7
    mk(OP_RD, 5, 1, 0, 10'h040),   // R5
    mk(OP_TXP, 2, 0, 0, 10'h1A5),  // R2
    mk(OP_TXP, 2, 0, 0, 10'h233),  // R2
    mk(OP_IRQ, 7, 0, 0, 10'h003),  // R7
    mk(OP_WR, 6, 6, 10'h002, 0),   // R6 threshold 2
    mk(OP_RXP, 6, 0, 10'h011, 0),
    mk(OP_RXP, 6, 0, 10'h022, 0),
    mk(OP_IRQ, 6, 0, 0, 10'h003),  // R6 two entries: not yet
    mk(OP_RXP, 6, 0, 10'h033, 0),
    mk(OP_IRQ, 6, 0, 0, 10'h007),  // R6 three entries: fires
    mk(OP_RD, 4, 5, 0, 10'h002),   // R4
    mk(OP_RD, 5, 1, 0, 10'h080),   // R5
    mk(OP_RD, 9, 3, 0, 10'h011),   // R9
    mk(OP_IRQ, 6, 0, 0, 10'h003),  // R6
    mk(OP_RD, 9, 3, 0, 10'h022),
    mk(OP_RD, 9, 3, 0, 10'h033),
    mk(OP_RD, 9, 3, 0, 10'h000),   // R9 empty read
    mk(OP_RD, 9, 5, 0, 10'h000),
    mk(OP_RD, 9, 1, 0, 10'h0C0),
    mk(OP_WR, 8, 0, 10'h002, 0),   // R8 flush on
    mk(OP_WR, 8, 2, 10'h055, 0),   // R8 dropped
    mk(OP_RD, 8, 1, 0, 10'h0C0),
    mk(OP_RD, 8, 0, 0, 10'h002),
    mk(OP_WR, 8, 0, 10'h000, 0),   // R8 release
    mk(OP_WR, 8, 2, 10'h077, 0),
    mk(OP_RD, 8, 4, 0, 10'h000),
    mk(OP_TXP, 8, 0, 0, 10'h077),
    mk(OP_RD, 3, 7, 0, 10'h000)    // R3 flush drop sets no overflow
  };

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_write = 0, tx_pop = 0, rx_push = 0;
  logic [2:0] host_addr = 0;
  logic [9:0] host_wdata = 0;
  logic [7:0] rx_byte = 0;
  logic [9:0] host_rdata, tx_head;
  logic irq_tx_empty, irq_tx_half, irq_rx_full;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_fifo_pair uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_pop(tx_pop), .tx_head(tx_head), .rx_push(rx_push), .rx_byte(rx_byte),
    .irq_tx_empty(irq_tx_empty), .irq_tx_half(irq_tx_half), .irq_rx_full(irq_rx_full));

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk); host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_valid = 0; host_write = 0;
  endtask

  task automatic hrd(input logic [2:0] a, input logic [9:0] e, input string tag);
    @(negedge clk); host_valid = 1; host_write = 0; host_addr = a;
    #1 chk(tag, host_rdata, e);
    @(posedge clk); #1 host_valid = 0;
  endtask

  task automatic rxp(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_byte = d;
    @(posedge clk); #1 rx_push = 0;
  endtask

  task automatic txp(input logic [9:0] e, input bit do_chk, input string tag);
    @(negedge clk); tx_pop = 1;
    #1 if (do_chk) chk(tag, tx_head, e);
    @(posedge clk); #1 tx_pop = 0;
  endtask

  task automatic irq(input logic [9:0] e, input string tag);
    @(negedge clk); #1 chk(tag, {7'b0, irq_rx_full, irq_tx_half, irq_tx_empty}, e);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [9:0] txval(input int i);
    return 10'((i * 37 + 5) ^ (i << 8));
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v = VEC[i];
      string tag = $sformatf("R%0d vec %0d", v[27:24], i);
      case (v[31:28])
        OP_WR:  hwr(v[22:20], v[19:10]);
        OP_RD:  hrd(v[22:20], v[9:0], tag);
        OP_RXP: rxp(v[17:10]);
        OP_TXP: txp(v[9:0], 1, tag);
        default: irq(v[9:0], tag);
      endcase
    end

    // R7 half boundary and R3 overflow
    for (int i = 0; i < 8; i++) hwr(2, txval(i));
    irq(10'h002, "R7 eight entries half");
    hwr(2, txval(8));
    irq(10'h000, "R7 nine entries not half");
    for (int i = 9; i < 16; i++) hwr(2, txval(i));
    hrd(1, 10'h050, "R5 tx full status");
    hrd(4, 10'h00F, "R4 tx occupancy full");
    hwr(2, 10'h3FF);
    hrd(7, 10'h001, "R3 overflow bit");
    hrd(4, 10'h00F, "R3 occupancy unchanged");
    for (int i = 0; i < 16; i++) txp(txval(i), 1, "R2 order");
    irq(10'h003, "R7 empty after drain");

    // R10 receive drop at full
    for (int i = 0; i < 16; i++) rxp(8'(8'hA0 + i));
    rxp(8'hEE);
    hrd(1, 10'h0A0, "R5 rx full status");
    hrd(5, 10'h00F, "R10 rx occupancy");
    for (int i = 0; i < 16; i++) hrd(3, 10'(8'hA0 + i), "R10 rx order");
    hrd(1, 10'h0C0, "R10 rx drained");

    // R10 pop on empty transmit queue
    txp(10'h000, 0, "R10");
    hwr(2, 10'h12F);
    hrd(4, 10'h000, "R10 one entry after empty pop");
    txp(10'h12F, 1, "R10 head intact");

    // R8 flush discards held entries
    hwr(2, 10'h011); hwr(2, 10'h022); hwr(2, 10'h033);
    hwr(0, 10'h002);
    hwr(0, 10'h000);
    hrd(4, 10'h000, "R8 occupancy after flush");
    hrd(1, 10'h0C0, "R8 status after flush");
    hrd(7, 10'h001, "R3 overflow still set");

    // R1 reset
    rxp(8'h5A);
    do_reset();
    hrd(1, 10'h0C0, "R1 status");
    hrd(7, 10'h000, "R1 debug");
    hrd(6, 10'h000, "R1 threshold");
    hrd(0, 10'h000, "R1 control");
    irq(10'h003, "R1 irqs");

    finish_run();
  end
endmodule